// File: doc/BRIEF.md
# Burst-4 Separate-Port SRAM Controller

This block sits on the host side of a quad-data-rate SRAM that has separate read and write data ports and a fixed burst of four words. Reads and writes enter on two valid/ready request channels. Each accepted request becomes one command cycle on the memory pins: an active-low read select or write select, plus a shared address, all registered on the rising edge of the main clock.

Double-rate signalling is modelled as two phase slots per clock cycle. The "rise" slot stands for the rising edge of the main clock, and the "fall" slot stands for the rising edge of its complement. A write burst is split into four words on the two write data lanes over the two cycles after its command. For a read, the four returned words are picked up from the read data lanes at a fixed half-cycle latency. They are then handed back as one four-word response with a single-cycle valid strobe.

The device ignores a second same-type command on consecutive cycles. The request channels therefore withhold readiness for one cycle after each acceptance. Only one address bus exists, so a read and a write are never issued in the same cycle, and the read goes first.

Top module: `sram4_ctrl`

## Requirements
- R1: While reset is asserted and right after it, both selects are high, both ready outputs are high, `rsp_valid_o` is low and both write data lanes are zero.
- R2: A request accepted at the clock edge that ends cycle u drives its select low during cycle u+1, with `mem_addr_o` equal to the accepted address.
- R3: When a read is accepted in a cycle, `wr_ready_o` is low in that same cycle, so the pending write is held over.
- R4: After a request of one type is accepted, that type's ready output is low for exactly the next cycle. No select is low on two consecutive cycles.
- R5: In any cycle that does not follow the acceptance of a request of its type, the select is high.
- R6: For a write command in cycle t, write word k sits at bits [k*DATA_W +: DATA_W] of `wr_data_i`. Word 0 appears on `mem_wd_rise_o` and word 1 on `mem_wd_fall_o` in cycle t+1. Word 2 appears on the rise lane and word 3 on the fall lane in cycle t+2.
- R7: In every other cycle both write data lanes are zero.
- R8: Half-slots are numbered from the read command cycle t: slot 2j is the rise slot of cycle t+j and slot 2j+1 is its fall slot. Read word k is taken from slot RD_LAT_HALF+k. With the default of 3, word 0 comes from the fall lane of t+1, words 1 and 2 from the rise and fall lanes of t+2, and word 3 from the rise lane of t+3.
- R9: `rsp_valid_o` is high for exactly one cycle: the cycle after the one that carries the last word. By default that is four cycles after the command cycle. `rsp_data_o` holds word k at bits [k*DATA_W +: DATA_W].
- R10: Reads issued every second cycle each yield their own response, in issue order. This holds even when one burst's last word and the next burst's first word share a cycle.
- R11: Values on the read data lanes outside a burst's four slots have no effect on any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request ready |
| rd_addr_i | input | ADDR_W | Read burst base address |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request ready |
| wr_addr_i | input | ADDR_W | Write burst base address |
| wr_data_i | input | 4*DATA_W | Write burst, word 0 in the low bits |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_data_o | output | 4*DATA_W | Read response, word 0 in the low bits |
| mem_rsel_n_o | output | 1 | Active-low read select to the memory |
| mem_wsel_n_o | output | 1 | Active-low write select to the memory |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wd_rise_o | output | DATA_W | Write data, rise slot |
| mem_wd_fall_o | output | DATA_W | Write data, fall slot |
| mem_q_rise_i | input | DATA_W | Read data, rise slot |
| mem_q_fall_i | input | DATA_W | Read data, fall slot |

## Verification
The write-data assertions look two and three cycles back at the handshake. They therefore assume that `wr_valid_i` is low during reset and that a requester holds valid, address and data steady until acceptance. The stimulus follows both rules: it raises valid only after reset and advances a request only after observing ready at the edge.

The bench's memory model answers every read command at the slot offsets stated in R8. In all other slots it drives a fixed junk value, so the response checks also cover R11. Address sweeps, back-to-back streams and simultaneous read/write streams keep every request inside the valid/ready contract.

// File: rtl/sram4_pkg.sv
package sram4_pkg;

    localparam int BURST_LEN = 4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_CMD,
        WS_TAIL
    } wr_phase_e;

    // cycle offset, from the read command cycle, of the last word of a burst
    function automatic int last_word_age(int lat_half);
        return (lat_half + BURST_LEN - 1) / 2;
    endfunction

endpackage

// File: rtl/sram4_cmd_issue.sv
module sram4_cmd_issue #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              rd_ready_o,
    output logic              wr_ready_o,
    output logic              wr_take_o,
    output logic              mem_rsel_n_o,
    output logic              mem_wsel_n_o,
    output logic [ADDR_W-1:0] mem_addr_o
);

    typedef struct packed {
        logic              rd_hold;
        logic              wr_hold;
        logic              rsel_n;
        logic              wsel_n;
        logic [ADDR_W-1:0] addr;
    } issue_st_t;

    issue_st_t s_d, s_q;
    logic      rd_take;

    always_comb begin
        s_d        = s_q;
        rd_ready_o = !s_q.rd_hold;
        rd_take    = rd_valid_i && rd_ready_o;
        // one address bus: a read in this cycle pushes the write back
        wr_ready_o = !s_q.wr_hold && !rd_take;
        wr_take_o  = wr_valid_i && wr_ready_o;

        s_d.rd_hold = rd_take;
        s_d.wr_hold = wr_take_o;
        s_d.rsel_n  = !rd_take;
        s_d.wsel_n  = !wr_take_o;
        if (rd_take) begin
            s_d.addr = rd_addr_i;
        end else if (wr_take_o) begin
            s_d.addr = wr_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{rd_hold: 1'b0, wr_hold: 1'b0, rsel_n: 1'b1, wsel_n: 1'b1, addr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_rsel_n_o = s_q.rsel_n;
    assign mem_wsel_n_o = s_q.wsel_n;
    assign mem_addr_o   = s_q.addr;

endmodule

// File: rtl/sram4_wr_serializer.sv
module sram4_wr_serializer
    import sram4_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_take_i,
    input  logic [BURST_LEN*DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]             wd_rise_o,
    output logic [DATA_W-1:0]             wd_fall_o
);

    typedef struct packed {
        wr_phase_e                          phase;
        logic [BURST_LEN-1:0][DATA_W-1:0]   words;
        logic [DATA_W-1:0]                  rise;
        logic [DATA_W-1:0]                  fall;
    } ser_st_t;

    ser_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.rise = '0;
        s_d.fall = '0;
        unique case (s_q.phase)
            WS_CMD: begin
                s_d.rise  = s_q.words[0];
                s_d.fall  = s_q.words[1];
                s_d.phase = WS_TAIL;
            end
            WS_TAIL: begin
                s_d.rise  = s_q.words[2];
                s_d.fall  = s_q.words[3];
                s_d.phase = WS_IDLE;
            end
            default: s_d.phase = WS_IDLE;
        endcase
        // a new write may be taken while the tail of the last one goes out
        if (wr_take_i) begin
            s_d.words = wr_data_i;
            s_d.phase = WS_CMD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: WS_IDLE, words: '0, rise: '0, fall: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wd_rise_o = s_q.rise;
    assign wd_fall_o = s_q.fall;

endmodule

// File: rtl/sram4_rd_collector.sv
module sram4_rd_collector
    import sram4_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RD_LAT_HALF = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_issue_i,
    input  logic [DATA_W-1:0]             q_rise_i,
    input  logic [DATA_W-1:0]             q_fall_i,
    output logic                          rsp_valid_o,
    output logic [BURST_LEN*DATA_W-1:0]   rsp_data_o
);

    localparam int MAX_AGE = last_word_age(RD_LAT_HALF);

    typedef struct packed {
        logic [MAX_AGE-1:0]                 hist;
        logic [BURST_LEN-1:0][DATA_W-1:0]   words;
        logic                               valid;
        logic [BURST_LEN-1:0][DATA_W-1:0]   data;
    } col_st_t;

    col_st_t          s_d, s_q;
    logic [MAX_AGE:0] age;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        age       = {s_q.hist, rd_issue_i};
        // rise slots first: a finishing burst is copied out before the
        // next burst's first word can land in the fall slot
        for (int j = 0; j <= MAX_AGE; j++) begin
            int widx;
            widx = 2 * j - RD_LAT_HALF;
            if (age[j] && widx >= 0 && widx < BURST_LEN) begin
                s_d.words[widx[1:0]] = q_rise_i;
                if (widx == BURST_LEN - 1) begin
                    s_d.valid = 1'b1;
                    s_d.data  = s_d.words;
                end
            end
        end
        for (int j = 0; j <= MAX_AGE; j++) begin
            int widx;
            widx = 2 * j + 1 - RD_LAT_HALF;
            if (age[j] && widx >= 0 && widx < BURST_LEN) begin
                s_d.words[widx[1:0]] = q_fall_i;
                if (widx == BURST_LEN - 1) begin
                    s_d.valid = 1'b1;
                    s_d.data  = s_d.words;
                end
            end
        end
        s_d.hist = age[MAX_AGE-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{hist: '0, words: '0, valid: 1'b0, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o = s_q.valid;
    assign rsp_data_o  = s_q.data;

endmodule

// File: rtl/sram4_ctrl.sv
module sram4_ctrl
    import sram4_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int RD_LAT_HALF = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_valid_i,
    output logic                          rd_ready_o,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    input  logic                          wr_valid_i,
    output logic                          wr_ready_o,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [BURST_LEN*DATA_W-1:0]   wr_data_i,
    output logic                          rsp_valid_o,
    output logic [BURST_LEN*DATA_W-1:0]   rsp_data_o,
    output logic                          mem_rsel_n_o,
    output logic                          mem_wsel_n_o,
    output logic [ADDR_W-1:0]             mem_addr_o,
    output logic [DATA_W-1:0]             mem_wd_rise_o,
    output logic [DATA_W-1:0]             mem_wd_fall_o,
    input  logic [DATA_W-1:0]             mem_q_rise_i,
    input  logic [DATA_W-1:0]             mem_q_fall_i
);

    logic wr_take;
    logic rd_issue;

    sram4_cmd_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_valid_i   (rd_valid_i),
        .rd_addr_i    (rd_addr_i),
        .wr_valid_i   (wr_valid_i),
        .wr_addr_i    (wr_addr_i),
        .rd_ready_o   (rd_ready_o),
        .wr_ready_o   (wr_ready_o),
        .wr_take_o    (wr_take),
        .mem_rsel_n_o (mem_rsel_n_o),
        .mem_wsel_n_o (mem_wsel_n_o),
        .mem_addr_o   (mem_addr_o)
    );

    sram4_wr_serializer #(.DATA_W(DATA_W)) u_wser (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_take_i (wr_take),
        .wr_data_i (wr_data_i),
        .wd_rise_o (mem_wd_rise_o),
        .wd_fall_o (mem_wd_fall_o)
    );

    assign rd_issue = !mem_rsel_n_o;

    sram4_rd_collector #(.DATA_W(DATA_W), .RD_LAT_HALF(RD_LAT_HALF)) u_rcol (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_issue_i  (rd_issue),
        .q_rise_i    (mem_q_rise_i),
        .q_fall_i    (mem_q_fall_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );

endmodule

// File: rtl/sram4_ctrl_chk.sv
module sram4_ctrl_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_valid_i,
    input logic                rd_ready_o,
    input logic [ADDR_W-1:0]   rd_addr_i,
    input logic                wr_valid_i,
    input logic                wr_ready_o,
    input logic [ADDR_W-1:0]   wr_addr_i,
    input logic [4*DATA_W-1:0] wr_data_i,
    input logic                rsp_valid_o,
    input logic                mem_rsel_n_o,
    input logic                mem_wsel_n_o,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [DATA_W-1:0]   mem_wd_rise_o,
    input logic [DATA_W-1:0]   mem_wd_fall_o
);

    // R2
    rd_cmd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_ready_o) |=> (!mem_rsel_n_o && mem_addr_o == $past(rd_addr_i)));

    // R2
    wr_cmd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o) |=> (!mem_wsel_n_o && mem_addr_o == $past(wr_addr_i)));

    // R3
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_ready_o) |-> !wr_ready_o);

    // R4
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rsel_n_o |=> mem_rsel_n_o);

    // R4
    wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wsel_n_o |=> mem_wsel_n_o);

    // R5
    rsel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rsel_n_o |-> $past(rd_valid_i && rd_ready_o));

    // R6
    wd_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid_i && wr_ready_o, 2) |->
            (mem_wd_rise_o == $past(wr_data_i[DATA_W-1:0], 2) &&
             mem_wd_fall_o == $past(wr_data_i[2*DATA_W-1:DATA_W], 2)));

    // R6
    wd_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid_i && wr_ready_o, 3) |->
            (mem_wd_rise_o == $past(wr_data_i[3*DATA_W-1:2*DATA_W], 3) &&
             mem_wd_fall_o == $past(wr_data_i[4*DATA_W-1:3*DATA_W], 3)));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

endmodule

bind sram4_ctrl sram4_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid_i    (rd_valid_i),
    .rd_ready_o    (rd_ready_o),
    .rd_addr_i     (rd_addr_i),
    .wr_valid_i    (wr_valid_i),
    .wr_ready_o    (wr_ready_o),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .rsp_valid_o   (rsp_valid_o),
    .mem_rsel_n_o  (mem_rsel_n_o),
    .mem_wsel_n_o  (mem_wsel_n_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wd_rise_o (mem_wd_rise_o),
    .mem_wd_fall_o (mem_wd_fall_o)
);

// File: tb/sim_sram4_ctrl.sv
`timescale 1ns/1ps
module sim_sram4_ctrl;

    localparam int AW        = 6;
    localparam int DW        = 8;
    localparam int LAT       = 3;
    localparam int RSP_DELAY = 2 + (LAT + 3) / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_valid_i = 1'b0;
    logic            rd_ready_o;
    logic [AW-1:0]   rd_addr_i = '0;
    logic            wr_valid_i = 1'b0;
    logic            wr_ready_o;
    logic [AW-1:0]   wr_addr_i = '0;
    logic [4*DW-1:0] wr_data_i = '0;
    logic            rsp_valid_o;
    logic [4*DW-1:0] rsp_data_o;
    logic            mem_rsel_n_o;
    logic            mem_wsel_n_o;
    logic [AW-1:0]   mem_addr_o;
    logic [DW-1:0]   mem_wd_rise_o;
    logic [DW-1:0]   mem_wd_fall_o;
    logic [DW-1:0]   mem_q_rise_i = '0;
    logic [DW-1:0]   mem_q_fall_i = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sram4_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT_HALF(LAT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o), .rd_addr_i(rd_addr_i),
        .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
        .mem_rsel_n_o(mem_rsel_n_o), .mem_wsel_n_o(mem_wsel_n_o), .mem_addr_o(mem_addr_o),
        .mem_wd_rise_o(mem_wd_rise_o), .mem_wd_fall_o(mem_wd_fall_o),
        .mem_q_rise_i(mem_q_rise_i), .mem_q_fall_i(mem_q_fall_i)
    );

    function automatic logic [DW-1:0] dev_word(int a, int k);
        return DW'((a * 37 + k * 11 + 3) & 255);
    endfunction

    function automatic logic [4*DW-1:0] wr_pattern(int a);
        logic [4*DW-1:0] v;
        for (int k = 0; k < 4; k++) v[k*DW +: DW] = DW'(((a * 4 + k) * 13 + 7) & 255);
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor state
    bit              last_rd_acc, last_wr_acc;
    logic [AW-1:0]   last_rd_addr, last_wr_addr;
    bit              ewd_v [8];
    logic [DW-1:0]   ewd_r [8];
    logic [DW-1:0]   ewd_f [8];
    bit              ersp_v [8];
    logic [4*DW-1:0] ersp_d [8];
    bit              hv [4];
    int              ha [4];

    // monitor and memory model, mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                chk("R1 rsel_n", mem_rsel_n_o, 1);
                chk("R1 wsel_n", mem_wsel_n_o, 1);
                chk("R1 rsp_valid", rsp_valid_o, 0);
                chk("R1 rd_ready", rd_ready_o, 1);
                chk("R1 wr_ready", wr_ready_o, 1);
                chk("R1 wd", {mem_wd_rise_o, mem_wd_fall_o}, 0);
                last_rd_acc = 0;
                last_wr_acc = 0;
                for (int i = 0; i < 8; i++) begin
                    ewd_v[i] = 0;
                    ersp_v[i] = 0;
                end
                for (int i = 0; i < 4; i++) hv[i] = 0;
                continue;
            end
            begin
                int  idx;
                bit  exp_rr, rd_acc, wr_acc;
                logic [DW-1:0] qr, qf;
                idx = cyc % 8;
                exp_rr = !last_rd_acc;
                chk("R4 rd_ready", rd_ready_o, exp_rr);
                chk("R3 R4 wr_ready", wr_ready_o, !last_wr_acc && !(rd_valid_i && exp_rr));
                chk("R2 R5 rsel_n", mem_rsel_n_o, !last_rd_acc);
                chk("R2 R5 wsel_n", mem_wsel_n_o, !last_wr_acc);
                if (last_rd_acc) chk("R2 read addr", mem_addr_o, last_rd_addr);
                if (last_wr_acc) chk("R2 write addr", mem_addr_o, last_wr_addr);
                if (ewd_v[idx]) begin
                    chk("R6 wd_rise", mem_wd_rise_o, ewd_r[idx]);
                    chk("R6 wd_fall", mem_wd_fall_o, ewd_f[idx]);
                end else begin
                    chk("R7 wd idle", {mem_wd_rise_o, mem_wd_fall_o}, 0);
                end
                ewd_v[idx] = 0;
                if (ersp_v[idx]) begin
                    chk("R9 rsp_valid", rsp_valid_o, 1);
                    chk("R8 R10 R11 rsp_data", rsp_data_o, ersp_d[idx]);
                end else begin
                    chk("R9 rsp idle", rsp_valid_o, 0);
                end
                ersp_v[idx] = 0;

                rd_acc = rd_valid_i && rd_ready_o;
                wr_acc = wr_valid_i && wr_ready_o;
                if (rd_acc) begin
                    int di;
                    di = (cyc + RSP_DELAY) % 8;
                    ersp_v[di] = 1;
                    for (int k = 0; k < 4; k++) ersp_d[di][k*DW +: DW] = dev_word(int'(rd_addr_i), k);
                end
                if (wr_acc) begin
                    ewd_v[(cyc + 2) % 8] = 1;
                    ewd_r[(cyc + 2) % 8] = wr_data_i[0*DW +: DW];
                    ewd_f[(cyc + 2) % 8] = wr_data_i[1*DW +: DW];
                    ewd_v[(cyc + 3) % 8] = 1;
                    ewd_r[(cyc + 3) % 8] = wr_data_i[2*DW +: DW];
                    ewd_f[(cyc + 3) % 8] = wr_data_i[3*DW +: DW];
                end
                last_rd_acc = rd_acc;
                last_rd_addr = rd_addr_i;
                last_wr_acc = wr_acc;
                last_wr_addr = wr_addr_i;

                // memory model: junk outside burst slots (R11)
                for (int j = 3; j > 0; j--) begin
                    hv[j] = hv[j-1];
                    ha[j] = ha[j-1];
                end
                hv[0] = !mem_rsel_n_o;
                ha[0] = int'(mem_addr_o);
                qr = 8'hEE;
                qf = 8'hEE;
                for (int j = 0; j < 4; j++) begin
                    if (hv[j]) begin
                        int wr_i;
                        wr_i = 2 * j - LAT;
                        if (wr_i >= 0 && wr_i < 4) qr = dev_word(ha[j], wr_i);
                        if (wr_i + 1 >= 0 && wr_i + 1 < 4) qf = dev_word(ha[j], wr_i + 1);
                    end
                end
                mem_q_rise_i = qr;
                mem_q_fall_i = qf;
            end
        end
    end

    task automatic idle(int n);
        rd_valid_i = 0;
        wr_valid_i = 0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // holds both channels busy until nrd reads and nwr writes are taken
    task automatic stream(int nrd, int nwr, int rbase, int wbase, int rstep, int wstep);
        int ri = 0;
        int wi = 0;
        while (ri < nrd || wi < nwr) begin
            bit r_acc, w_acc;
            rd_valid_i = (ri < nrd);
            rd_addr_i  = AW'((rbase + ri * rstep) % 64);
            wr_valid_i = (wi < nwr);
            wr_addr_i  = AW'((wbase + wi * wstep) % 64);
            wr_data_i  = wr_pattern((wbase + wi * wstep) % 64);
            #1;
            r_acc = rd_valid_i && rd_ready_o;
            w_acc = wr_valid_i && wr_ready_o;
            @(posedge clk);
            #1;
            if (r_acc) ri++;
            if (w_acc) wi++;
        end
        rd_valid_i = 0;
        wr_valid_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);
        // R6 R7: every write address alone
        for (int a = 0; a < 64; a++) begin
            stream(0, 1, 0, a, 1, 1);
            idle(4);
        end
        // R8 R9 R11: every read address alone
        for (int a = 0; a < 64; a++) begin
            stream(1, 0, a, 0, 1, 1);
            idle(6);
        end
        // R10 R4: reads held back to back
        stream(12, 0, 3, 0, 7, 1);
        idle(7);
        // R4: writes held back to back
        stream(0, 10, 0, 9, 1, 5);
        idle(5);
        // R3: both channels busy at once
        stream(8, 8, 10, 20, 3, 11);
        idle(7);
        stream(3, 12, 40, 1, 9, 2);
        idle(7);
        stream(16, 2, 5, 60, 13, 1);
        idle(8);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule